// File: doc/BRIEF.md
# Banked Dual Stack Pointer Unit

This block keeps two stack pointers, one for the main stack and one for the process stack, and decides which one is active from the current execution mode and a small control register. In handler mode the main pointer is always active and execution is always privileged. In thread mode, one control bit picks the pointer and another picks the privilege level. Only privileged code may change the control register; writes from unprivileged code are dropped.

Stack operations arrive as a valid/ready request stream. An accepted push decrements the active pointer by one word and reports the new value as the store address. An accepted pop reports the current pointer as the load address and then increments the pointer by one word. Each accepted request produces one address beat on a valid/ready output stream. That beat is held, unchanged, until the consumer takes it. A new request is accepted only when the output register is empty or is being emptied in the same cycle, and never in a cycle with a direct pointer write. Software can load either pointer directly; the two low bits of every pointer are kept at zero.

Top module: `dual_sp_unit`

## Requirements
- R1: After reset the main pointer holds MSP_INIT and is active in thread mode, `priv_now` is 1, the control register is 0, and `addr_valid` is 0.
- R2: An accepted push (`op_push`=1) stores active SP minus 4 into the active pointer and, on the next cycle, presents that value on `addr_out` with `addr_valid`=1 and `addr_is_push`=1.
- R3: An accepted pop (`op_push`=0) presents the active SP on `addr_out` on the next cycle with `addr_is_push`=0, and the active pointer becomes SP plus 4.
- R4: When `is_handler`=1, the main pointer is active and `priv_now`=1, whatever the control bits are; stack operations in handler mode never change the process pointer.
- R5: When `is_handler`=0, control bit 1 (`ctrl_wdata[1]`) selects the process pointer when 1 and the main pointer when 0. Control bit 0 makes execution unprivileged when 1.
- R6: A control write (`ctrl_we`) takes effect on the next cycle only if `priv_now`=1 in the cycle of the write; otherwise it is ignored.
- R7: A direct write (`sp_we`) loads `sp_wdata` with its two low bits cleared into the main pointer (`sp_sel`=0) or the process pointer (`sp_sel`=1) on the next edge. `op_ready` is 0 in that cycle.
- R8: `op_ready` = (not `addr_valid` or `addr_ready`) and not `sp_we`. While `addr_valid`=1 and `addr_ready`=0, `addr_out` and `addr_is_push` hold. A taken beat with no new request clears `addr_valid`.
- R9: The two pointers are independent. An operation or direct write on one pointer leaves the other one unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_handler | input | 1 | 1 = handler mode, 0 = thread mode |
| ctrl_we | input | 1 | Control register write request |
| ctrl_wdata | input | 2 | Bit 1 process-stack select, bit 0 unprivileged |
| sp_we | input | 1 | Direct stack pointer write |
| sp_sel | input | 1 | Target of direct write: 0 main, 1 process |
| sp_wdata | input | ADDR_W | Direct write value |
| op_valid | input | 1 | Stack operation request valid |
| op_ready | output | 1 | Stack operation request accepted when high with valid |
| op_push | input | 1 | 1 = push, 0 = pop |
| addr_valid | output | 1 | Address beat valid |
| addr_ready | input | 1 | Consumer takes the address beat |
| addr_out | output | ADDR_W | Memory address of the operation |
| addr_is_push | output | 1 | Beat belongs to a push |
| sp_active | output | ADDR_W | Currently selected stack pointer |
| priv_now | output | 1 | Current execution is privileged |

## Verification
Directed sequences run pushes and pops on each pointer in thread mode, then the same operations in handler mode with process-stack selected. This separates a correct mode override from a pointer mux driven by the control bit alone. Writes to the control register are tried both before and after dropping privilege, so an ignored write shows up as an unchanged pointer selection at the ports. Constrained random traffic mixes direct writes, mode changes and a consumer that stalls at random. This exposes wrong stall handling, lost beats and updates that land on the wrong bank.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef struct packed {
    logic use_psp;
    logic unpriv;
  } ctrl_t;

  typedef enum logic {
    BANK_MAIN = 1'b0,
    BANK_PROC = 1'b1
  } bank_e;
endpackage

// File: rtl/dsp_ctrl_reg.sv
module dsp_ctrl_reg
  import dsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_handler,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output ctrl_t      ctrl_q,
  output logic       priv_now,
  output logic       use_psp
);
  // privilege is evaluated on the current cycle's mode and stored bits
  assign priv_now = is_handler | ~ctrl_q.unpriv;
  assign use_psp  = ~is_handler & ctrl_q.use_psp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en && priv_now) begin
      ctrl_q <= ctrl_t'(wr_data);
    end
  end
endmodule

// File: rtl/dsp_sp_bank.sv
module dsp_sp_bank
  import dsp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 2,
  parameter logic [ADDR_W-1:0] MSP_INIT = 32'h2000_8000,
  parameter logic [ADDR_W-1:0] PSP_INIT = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_psp,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_val,
  output logic [ADDR_W-1:0] sp_cur,
  output logic [ADDR_W-1:0] msp_q,
  output logic [ADDR_W-1:0] psp_q
);
  localparam int unsigned NUM_BANKS = 2;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] bank_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam logic [ADDR_W-1:0] INIT_VAL = ((g == 0) ? MSP_INIT : PSP_INIT) & ALIGN_MASK;
    logic hit_wr;
    logic hit_upd;
    assign hit_wr  = wr_en && (wr_sel == g[0]);
    assign hit_upd = upd_en && (sel_psp == g[0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_q[g] <= INIT_VAL;
      end else if (hit_wr) begin
        bank_q[g] <= wr_data & ALIGN_MASK;
      end else if (hit_upd) begin
        bank_q[g] <= upd_val & ALIGN_MASK;
      end
    end
  end

  assign msp_q  = bank_q[BANK_MAIN];
  assign psp_q  = bank_q[BANK_PROC];
  assign sp_cur = sel_psp ? psp_q : msp_q;
endmodule

// File: rtl/dsp_addr_gen.sv
module dsp_addr_gen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sp_cur,
  input  logic              op_fire,
  input  logic              op_push,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] sp_next,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_push
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] dec_sp;
  logic [ADDR_W-1:0] beat_addr;

  // full descending: push lands below the last item, pop reads it
  assign dec_sp    = sp_cur - STEP;
  assign sp_next   = op_push ? dec_sp : (sp_cur + STEP);
  assign beat_addr = op_push ? dec_sp : sp_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_push  <= 1'b0;
    end else if (op_fire) begin
      out_valid <= 1'b1;
      out_addr  <= beat_addr;
      out_push  <= op_push;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_sp_unit.sv
module dual_sp_unit
  import dsp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] MSP_INIT = 32'h2000_8000,
  parameter logic [ADDR_W-1:0] PSP_INIT = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_handler,
  input  logic              ctrl_we,
  input  logic [1:0]        ctrl_wdata,
  input  logic              sp_we,
  input  logic              sp_sel,
  input  logic [ADDR_W-1:0] sp_wdata,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_push,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_is_push,
  output logic [ADDR_W-1:0] sp_active,
  output logic              priv_now
);
  localparam int unsigned ALIGN_BITS = $clog2(WORD_BYTES);

  ctrl_t             ctrl_q;
  logic [1:0]        ctrl_bits;
  logic              use_psp;
  logic              op_fire;
  logic [ADDR_W-1:0] sp_next;
  logic [ADDR_W-1:0] msp_q;
  logic [ADDR_W-1:0] psp_q;

  assign ctrl_bits = ctrl_q;
  assign op_ready  = (~addr_valid | addr_ready) & ~sp_we;
  assign op_fire   = op_valid & op_ready;

  dsp_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_handler (is_handler),
    .wr_en      (ctrl_we),
    .wr_data    (ctrl_wdata),
    .ctrl_q     (ctrl_q),
    .priv_now   (priv_now),
    .use_psp    (use_psp)
  );

  dsp_sp_bank #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BITS (ALIGN_BITS),
    .MSP_INIT   (MSP_INIT),
    .PSP_INIT   (PSP_INIT)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_psp (use_psp),
    .wr_en   (sp_we),
    .wr_sel  (sp_sel),
    .wr_data (sp_wdata),
    .upd_en  (op_fire),
    .upd_val (sp_next),
    .sp_cur  (sp_active),
    .msp_q   (msp_q),
    .psp_q   (psp_q)
  );

  dsp_addr_gen #(
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_agen (
    .clk       (clk),
    .rst_n     (rst_n),
    .sp_cur    (sp_active),
    .op_fire   (op_fire),
    .op_push   (op_push),
    .out_ready (addr_ready),
    .sp_next   (sp_next),
    .out_valid (addr_valid),
    .out_addr  (addr_out),
    .out_push  (addr_is_push)
  );
endmodule

// File: rtl/dual_sp_unit_chk.sv
module dual_sp_unit_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              is_handler,
  input logic              ctrl_we,
  input logic              priv_now,
  input logic [1:0]        ctrl_bits,
  input logic              op_valid,
  input logic              op_ready,
  input logic              op_push,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_is_push,
  input logic [ADDR_W-1:0] sp_active,
  input logic [ADDR_W-1:0] psp_q
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  assert_unpriv_ctrl_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !priv_now) |=> (ctrl_bits == $past(ctrl_bits)));

  assert_push_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_push) |=>
      (addr_valid && addr_is_push && addr_out == $past(sp_active) - STEP));

  assert_pop_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !op_push) |=>
      (addr_valid && !addr_is_push && addr_out == $past(sp_active)));

  assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=>
      (addr_valid && $stable(addr_out) && $stable(addr_is_push)));

  assert_psp_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && is_handler) |=> $stable(psp_q));
endmodule

bind dual_sp_unit dual_sp_unit_chk #(
  .ADDR_W     (ADDR_W),
  .WORD_BYTES (WORD_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .is_handler   (is_handler),
  .ctrl_we      (ctrl_we),
  .priv_now     (priv_now),
  .ctrl_bits    (ctrl_bits),
  .op_valid     (op_valid),
  .op_ready     (op_ready),
  .op_push      (op_push),
  .addr_valid   (addr_valid),
  .addr_ready   (addr_ready),
  .addr_out     (addr_out),
  .addr_is_push (addr_is_push),
  .sp_active    (sp_active),
  .psp_q        (psp_q)
);

// File: tb/dual_sp_unit_tb.sv
`timescale 1ns/1ps
module dual_sp_unit_tb;
  localparam int unsigned AW = 32;
  localparam logic [AW-1:0] MSP0 = 32'h2000_8000;
  localparam logic [AW-1:0] PSP0 = 32'h0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          is_handler = 1'b0;
  logic          ctrl_we = 1'b0;
  logic [1:0]    ctrl_wdata = '0;
  logic          sp_we = 1'b0;
  logic          sp_sel = 1'b0;
  logic [AW-1:0] sp_wdata = '0;
  logic          op_valid = 1'b0;
  logic          op_push = 1'b0;
  logic          addr_ready = 1'b0;
  logic          op_ready;
  logic          addr_valid;
  logic [AW-1:0] addr_out;
  logic          addr_is_push;
  logic [AW-1:0] sp_active;
  logic          priv_now;

  always #4 clk = ~clk;

  dual_sp_unit #(.ADDR_W(AW), .WORD_BYTES(4), .MSP_INIT(MSP0), .PSP_INIT(PSP0)) u_dut (
    .clk(clk), .rst_n(rst_n), .is_handler(is_handler), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .sp_we(sp_we), .sp_sel(sp_sel), .sp_wdata(sp_wdata),
    .op_valid(op_valid), .op_ready(op_ready), .op_push(op_push),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
    .addr_is_push(addr_is_push), .sp_active(sp_active), .priv_now(priv_now)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [AW-1:0] m_msp, m_psp, m_addr;
  logic [1:0]    m_ctrl;
  logic          m_av, m_push;

  function automatic logic exp_priv();
    return is_handler | ~m_ctrl[0];
  endfunction
  function automatic logic exp_use_psp();
    return ~is_handler & m_ctrl[1];
  endfunction
  function automatic logic [AW-1:0] exp_sp();
    return exp_use_psp() ? m_psp : m_msp;
  endfunction
  function automatic logic exp_ready();
    return (~m_av | addr_ready) & ~sp_we;
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare every output with the reference for the current inputs
  task automatic check_all(input string t_sp, input string t_pr, input string t_ad);
    chk(t_sp, sp_active, exp_sp());
    chk(t_pr, {31'b0, priv_now}, {31'b0, exp_priv()});
    chk("R8 op_ready", {31'b0, op_ready}, {31'b0, exp_ready()});
    chk(t_ad, {31'b0, addr_valid}, {31'b0, m_av});
    if (m_av) begin
      chk(t_ad, addr_out, m_addr);
      chk(t_ad, {31'b0, addr_is_push}, {31'b0, m_push});
    end
  endtask

  // advance the reference by one clock edge using the present inputs
  task automatic model_edge();
    logic [AW-1:0] cur, nsp;
    logic acc;
    cur = exp_sp();
    acc = op_valid & exp_ready();
    if (acc) begin
      nsp = op_push ? cur - 4 : cur + 4;
      m_addr = op_push ? cur - 4 : cur;
      m_push = op_push;
      m_av = 1'b1;
      if (exp_use_psp()) m_psp = nsp; else m_msp = nsp;
    end else if (addr_ready) begin
      m_av = 1'b0;
    end
    if (sp_we) begin
      if (sp_sel) m_psp = sp_wdata & ~32'h3; else m_msp = sp_wdata & ~32'h3;
    end
    if (ctrl_we && exp_priv()) m_ctrl = ctrl_wdata;
  endtask

  // apply inputs (we are just after a negedge), step, sample at next negedge
  task automatic step(input logic hnd, input logic cwe, input logic [1:0] cwd,
                      input logic swe, input logic ssel, input logic [AW-1:0] swd,
                      input logic ov, input logic opu, input logic ar,
                      input string t_sp, input string t_pr, input string t_ad);
    is_handler = hnd; ctrl_we = cwe; ctrl_wdata = cwd; sp_we = swe; sp_sel = ssel;
    sp_wdata = swd; op_valid = ov; op_push = opu; addr_ready = ar;
    #1;
    chk("R8 op_ready pre", {31'b0, op_ready}, {31'b0, exp_ready()});
    model_edge();
    @(negedge clk);
    ctrl_we = 1'b0; sp_we = 1'b0; op_valid = 1'b0;
    #1;
    check_all(t_sp, t_pr, t_ad);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    m_msp = MSP0; m_psp = PSP0; m_ctrl = 2'b00; m_av = 1'b0; m_addr = '0; m_push = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 sp_active", sp_active, MSP0);
    chk("R1 priv_now", {31'b0, priv_now}, 32'd1);
    chk("R1 addr_valid", {31'b0, addr_valid}, 32'd0);

    // R2 push on main stack, consumer ready
    step(0, 0, 2'b00, 0, 0, '0, 1, 1, 1, "R2 sp", "R1 priv", "R2 addr");
    chk("R2 push addr", addr_out, MSP0 - 4);
    // R3 pop returns the same word address
    step(0, 0, 2'b00, 0, 0, '0, 1, 0, 1, "R3 sp", "R1 priv", "R3 addr");
    chk("R3 pop addr", addr_out, MSP0 - 4);
    chk("R3 sp after pop", sp_active, MSP0);
    // R7 direct write with low bits set, stalls op
    step(0, 0, 2'b00, 1, 1, 32'h1000_0107, 1, 1, 1, "R7 sp", "R1 priv", "R7 addr");
    // R5 select process stack in thread mode
    step(0, 1, 2'b10, 0, 0, '0, 0, 0, 1, "R5 sp", "R5 priv", "R8 addr");
    chk("R7 psp aligned", sp_active, 32'h1000_0104);
    // R9 push on process leaves main alone
    step(0, 0, 2'b00, 0, 0, '0, 1, 1, 1, "R9 sp", "R5 priv", "R2 addr");
    // R4 handler forces main, push there leaves process stack alone
    step(1, 0, 2'b00, 0, 0, '0, 1, 1, 1, "R4 sp", "R4 priv", "R4 addr");
    chk("R4 handler main", sp_active, MSP0 - 4);
    // R8 back-pressure: push, then stall with a new request pending
    step(1, 0, 2'b00, 0, 0, '0, 1, 1, 0, "R8 sp", "R4 priv", "R8 addr");
    step(1, 0, 2'b00, 0, 0, '0, 1, 0, 0, "R8 sp", "R4 priv", "R8 hold");
    step(1, 0, 2'b00, 0, 0, '0, 0, 0, 1, "R8 sp", "R4 priv", "R8 drain");
    // R5 drop privilege in thread mode, keep process stack
    step(0, 1, 2'b11, 0, 0, '0, 0, 0, 1, "R5 sp", "R5 priv", "R8 addr");
    chk("R5 unpriv", {31'b0, priv_now}, 32'd0);
    // R6 unprivileged write tries to select main and regain privilege
    step(0, 1, 2'b00, 0, 0, '0, 0, 0, 1, "R6 sp", "R6 priv", "R8 addr");
    chk("R6 ignored priv", {31'b0, priv_now}, 32'd0);
    chk("R6 ignored sel", sp_active, 32'h1000_0100);
    // R6 privileged write from handler restores
    step(1, 1, 2'b00, 0, 0, '0, 0, 0, 1, "R6 sp", "R6 priv", "R8 addr");
    step(0, 0, 2'b00, 0, 0, '0, 0, 0, 1, "R6 sp", "R6 priv", "R8 addr");
    chk("R6 restored", {31'b0, priv_now}, 32'd1);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic hnd, cwe, swe, ov, ar;
      hnd = ($urandom_range(0, 9) < 3);
      cwe = ($urandom_range(0, 9) == 0);
      swe = ($urandom_range(0, 15) == 0);
      ov  = ($urandom_range(0, 9) < 6);
      ar  = ($urandom_range(0, 9) < 7);
      step(hnd, cwe, 2'($urandom), swe, 1'($urandom), $urandom, ov, 1'($urandom), ar,
           "R9 sp", "R5 priv", "R8 addr");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule